// File: doc/BRIEF.md
# Data-Dependent Vector Length Truncation Unit

This block follows the element results of a vector operation one by one, in ascending element order, and cuts the vector length short at the first element whose result is zero. A typical use is a byte-string copy loop. Elements are loaded and tested, and the loop stops at the terminating NUL. Writeback of every element past the cut point is suppressed, so those destination registers keep their old contents. A mode select decides whether the failing element itself is written and counted (inclusive) or dropped (exclusive).

A `start` pulse fixes the length of the new vector. The length comes from one of two places: the requested length on `vl_req_i`, or, for strip-mined loops, the remaining loop count on `remain_i` clipped to the parameter `MAXVL`. Both sources are clipped to `MAXVL`. While running, each accepted element sets its bit in the write mask. When the failing element or the last element has been taken in, the unit registers the final length and raises `done_o` until the next start.

The controller has three states. IDLE is the state after reset. RUN means elements are being accepted. DONE means the result is final. The transitions are:
- start with a non-zero length: any state to RUN.
- start with a zero length: any state to DONE.
- in RUN, a strobed element that is zero, or that is the last element: RUN to DONE.
- all other cycles: the state holds.

Top module: `ddff_trunc`

## Requirements
- R1: After reset `done_o` is 0, `vl_o` is 0 and `wr_mask_o` is all zeros.
- R2: At `start_i` the vector length is min(`vl_req_i`, MAXVL) when `strip_en_i` is 0, and min(`remain_i`, MAXVL) when `strip_en_i` is 1. In strip mode `vl_req_i` has no effect.
- R3: Elements are numbered 0, 1, 2 … in the order their `elem_valid_i` strobes arrive. Idle cycles between strobes do not advance the index. The first element whose `elem_data_i` equals zero ends the vector.
- R4: Exclusive mode (`incl_i` = 0 at start): when element k is zero, `vl_o` becomes k and bit k of `wr_mask_o` stays 0.
- R5: Inclusive mode (`incl_i` = 1 at start): when element k is zero, `vl_o` becomes k+1 and bit k of `wr_mask_o` is 1.
- R6: When none of the elements is zero, the final `vl_o` equals the length fixed at start.
- R7: Bit i of `wr_mask_o` (bit i belongs to element i) is 1 exactly when i < final `vl_o`. Elements at or beyond the cut point are never enabled for writeback.
- R8: Once `done_o` is 1, further element strobes change neither `vl_o` nor `wr_mask_o` until the next start.
- R9: A start with length zero gives `done_o` = 1, `vl_o` = 0 and an all-zero mask in the next cycle.
- R10: `done_o` is 0 while elements are expected. It rises in the cycle after the clock edge that takes in the failing element or the last element, and the final `vl_o` is valid from that same cycle.
- R11: A start pulse in any state, including mid-vector, discards the vector in progress and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new vector |
| strip_en_i | input | 1 | 1: length from remaining count; 0: from requested length |
| vl_req_i | input | VL_W | Requested vector length |
| remain_i | input | CNT_W | Remaining loop count for strip mining |
| incl_i | input | 1 | 1: inclusive truncation; 0: exclusive |
| elem_valid_i | input | 1 | Element result strobe |
| elem_data_i | input | DATA_W | Element result value |
| vl_o | output | VL_W | Resulting vector length |
| wr_mask_o | output | MAXVL | Writeback enable, one bit per element |
| done_o | output | 1 | Result final |

## Verification
The bench runs every requested length from 0 up to the widest value the length port can carry. For each length it places the zero element at every position, and also tries the case with no zero at all, in both inclusive and exclusive mode. This separates off-by-one errors in the cut position, a lost or wrongly included failing element, and the clipping of oversized requests. Some runs put idle cycles between strobes, which separates a correct element index from one that counts clock cycles. After each vector, extra zero and non-zero strobes are driven to show the result is frozen. Further runs cover remaining counts below, at and far above MAXVL, and a restart in the middle of a vector.

// File: rtl/ddff_pkg.sv
package ddff_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ff_state_e;
endpackage

// File: rtl/ddff_len_sel.sv
// Chooses the starting vector length and clips it to MAXVL.
module ddff_len_sel #(
    parameter int unsigned MAXVL = 8,
    parameter int unsigned CNT_W = 16,
    parameter int unsigned VL_W  = 4
) (
    input  logic             strip_en,
    input  logic [VL_W-1:0]  vl_req,
    input  logic [CNT_W-1:0] remain,
    output logic [VL_W-1:0]  len
);
    localparam logic [VL_W-1:0]  MAX_V = VL_W'(MAXVL);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAXVL);

    logic [VL_W-1:0] req_clip;
    logic [VL_W-1:0] cnt_clip;

    always_comb begin
        req_clip = (vl_req > MAX_V) ? MAX_V : vl_req;
        cnt_clip = (remain > MAX_C) ? MAX_V : remain[VL_W-1:0];
        len      = strip_en ? cnt_clip : req_clip;
    end
endmodule

// File: rtl/ddff_zero_det.sv
// Fail test on one element result: true when the value is zero.
module ddff_zero_det #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    output logic              is_zero
);
    assign is_zero = ~|data;
endmodule

// File: rtl/ddff_elem_dec.sv
// One-hot select of the element currently being accepted.
module ddff_elem_dec #(
    parameter int unsigned MAXVL = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic [IDX_W-1:0] idx,
    output logic [MAXVL-1:0] sel
);
    for (genvar g = 0; g < MAXVL; g++) begin : g_sel
        assign sel[g] = (idx == IDX_W'(g));
    end
endmodule

// File: rtl/ddff_trunc.sv
module ddff_trunc #(
    parameter int unsigned MAXVL  = 8,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 16,
    localparam int unsigned VL_W  = $clog2(MAXVL + 1),
    localparam int unsigned IDX_W = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              strip_en_i,
    input  logic [VL_W-1:0]   vl_req_i,
    input  logic [CNT_W-1:0]  remain_i,
    input  logic              incl_i,
    input  logic              elem_valid_i,
    input  logic [DATA_W-1:0] elem_data_i,
    output logic [VL_W-1:0]   vl_o,
    output logic [MAXVL-1:0]  wr_mask_o,
    output logic              done_o
);
    import ddff_pkg::*;

    ff_state_e        state_q, state_d;
    logic [VL_W-1:0]  len_w;
    logic [VL_W-1:0]  len_q;
    logic [IDX_W-1:0] idx_q;
    logic             incl_q;
    logic [VL_W-1:0]  vl_q;
    logic [MAXVL-1:0] mask_q;
    logic             is_zero;
    logic [MAXVL-1:0] sel;
    logic             last_elem;
    logic [VL_W-1:0]  idx_vl;

    ddff_len_sel #(.MAXVL(MAXVL), .CNT_W(CNT_W), .VL_W(VL_W)) u_len (
        .strip_en (strip_en_i),
        .vl_req   (vl_req_i),
        .remain   (remain_i),
        .len      (len_w)
    );

    ddff_zero_det #(.DATA_W(DATA_W)) u_zero (
        .data    (elem_data_i),
        .is_zero (is_zero)
    );

    ddff_elem_dec #(.MAXVL(MAXVL), .IDX_W(IDX_W)) u_dec (
        .idx (idx_q),
        .sel (sel)
    );

    assign idx_vl    = VL_W'(idx_q);
    assign last_elem = (idx_vl == (len_q - VL_W'(1)));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = (len_w == '0) ? ST_DONE : ST_RUN;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RUN: begin
                    if (elem_valid_i && (is_zero || last_elem)) begin
                        state_d = ST_DONE;
                    end
                end
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            idx_q  <= '0;
            incl_q <= 1'b0;
            vl_q   <= '0;
            mask_q <= '0;
        end else if (start_i) begin
            len_q  <= len_w;
            idx_q  <= '0;
            incl_q <= incl_i;
            vl_q   <= len_w;
            mask_q <= '0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (elem_valid_i) begin
                        if (is_zero) begin
                            if (incl_q) begin
                                mask_q <= mask_q | sel;
                                vl_q   <= idx_vl + VL_W'(1);
                            end else begin
                                vl_q   <= idx_vl;
                            end
                        end else begin
                            mask_q <= mask_q | sel;
                            if (last_elem) begin
                                vl_q <= len_q;
                            end else begin
                                idx_q <= idx_q + IDX_W'(1);
                            end
                        end
                    end
                end
                ST_IDLE, ST_DONE: begin
                    vl_q <= vl_q;
                end
                default: begin
                    vl_q <= vl_q;
                end
            endcase
        end
    end

    assign vl_o      = vl_q;
    assign wr_mask_o = mask_q;
    assign done_o    = (state_q == ST_DONE);
endmodule

// File: rtl/ddff_trunc_chk.sv
module ddff_trunc_chk #(
    parameter int unsigned MAXVL  = 8,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 16,
    localparam int unsigned VL_W  = $clog2(MAXVL + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              strip_en_i,
    input logic [VL_W-1:0]   vl_req_i,
    input logic [CNT_W-1:0]  remain_i,
    input logic              incl_i,
    input logic              elem_valid_i,
    input logic [DATA_W-1:0] elem_data_i,
    input logic [VL_W-1:0]   vl_o,
    input logic [MAXVL-1:0]  wr_mask_o,
    input logic              done_o
);
    logic zero_start;
    always_comb begin
        if (strip_en_i) zero_start = (remain_i == '0);
        else            zero_start = (vl_req_i == '0);
    end

    // R7: the mask holds exactly vl_o low bits once final
    assert_mask_matches_vl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($countones(wr_mask_o) == 32'(vl_o)));

    // R2: length never exceeds MAXVL
    assert_vl_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(vl_o) <= MAXVL);

    // R8: result frozen while done and no new start
    assert_frozen_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(vl_o) && $stable(wr_mask_o)));

    // R9: zero length ends at once
    assert_zero_len_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && zero_start) |=> (done_o && vl_o == '0 && wr_mask_o == '0));

    // R10, R11: non-empty start clears done and mask
    assert_start_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !zero_start) |=> (!done_o && wr_mask_o == '0));

    // R3: write enables only accumulate within one vector
    assert_mask_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !done_o) |=> ((wr_mask_o & $past(wr_mask_o)) == $past(wr_mask_o)));
endmodule

bind ddff_trunc ddff_trunc_chk #(.MAXVL(MAXVL), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/ddff_trunc_bench.sv
`timescale 1ns/1ps
module ddff_trunc_bench;
    localparam int MAXVL  = 8;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 16;
    localparam int VL_W   = $clog2(MAXVL + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              strip_en_i = 1'b0;
    logic [VL_W-1:0]   vl_req_i = '0;
    logic [CNT_W-1:0]  remain_i = '0;
    logic              incl_i = 1'b0;
    logic              elem_valid_i = 1'b0;
    logic [DATA_W-1:0] elem_data_i = '0;
    logic [VL_W-1:0]   vl_o;
    logic [MAXVL-1:0]  wr_mask_o;
    logic              done_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    ddff_trunc #(.MAXVL(MAXVL), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ddff_trunc (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .strip_en_i(strip_en_i),
        .vl_req_i(vl_req_i), .remain_i(remain_i), .incl_i(incl_i),
        .elem_valid_i(elem_valid_i), .elem_data_i(elem_data_i),
        .vl_o(vl_o), .wr_mask_o(wr_mask_o), .done_o(done_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog R10: act=%0d exp=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] elem_val(input int i, input int fpos);
        if (i == fpos) return '0;
        return DATA_W'(i * 37 + 1);
    endfunction

    task automatic pulse_start(input int vlreq, input bit strip, input int remain, input bit incl);
        @(negedge clk);
        start_i = 1'b1; strip_en_i = strip; vl_req_i = VL_W'(vlreq);
        remain_i = CNT_W'(remain); incl_i = incl; elem_valid_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_case(input int vlreq, input bit strip, input int remain,
                            input bit incl, input int fpos, input bit gaps);
        int len, exp_vl, steps;
        len = strip ? ((remain > MAXVL) ? MAXVL : remain)
                    : ((vlreq > MAXVL) ? MAXVL : vlreq);
        pulse_start(vlreq, strip, remain, incl);
        if (len == 0) begin
            chk("R9 done", int'(done_o), 1);
            chk("R9 vl", int'(vl_o), 0);
            chk("R9 mask", int'(wr_mask_o), 0);
            return;
        end
        chk("R10 done low at start", int'(done_o), 0);
        steps = 0;
        while (!done_o && steps < MAXVL + 2) begin
            if (gaps) begin
                elem_valid_i = 1'b0;
                elem_data_i = '0;
                @(negedge clk);
                chk("R3 idle cycle", int'(done_o), 0);
            end
            elem_valid_i = 1'b1;
            elem_data_i = elem_val(steps, fpos);
            @(negedge clk);
            elem_valid_i = 1'b0;
            chk("R10 done timing", int'(done_o), int'(steps == fpos || steps == len - 1));
            steps++;
        end
        if (fpos < len) exp_vl = incl ? fpos + 1 : fpos;
        else            exp_vl = len;
        if (fpos >= len)  chk(strip ? "R2 strip vl" : "R6 no fail vl", int'(vl_o), exp_vl);
        else if (incl)    chk("R5 inclusive vl", int'(vl_o), exp_vl);
        else              chk("R4 exclusive vl", int'(vl_o), exp_vl);
        chk("R7 mask", int'(wr_mask_o), (1 << exp_vl) - 1);
        // strobes after done must be ignored
        elem_valid_i = 1'b1; elem_data_i = '0;
        @(negedge clk);
        elem_data_i = 8'h5A;
        @(negedge clk);
        elem_valid_i = 1'b0;
        chk("R8 vl frozen", int'(vl_o), exp_vl);
        chk("R8 mask frozen", int'(wr_mask_o), (1 << exp_vl) - 1);
        chk("R8 done held", int'(done_o), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 done", int'(done_o), 0);
        chk("R1 vl", int'(vl_o), 0);
        chk("R1 mask", int'(wr_mask_o), 0);
        rst_n = 1'b1;

        // exhaustive sweep over requested length, fail position and mode
        for (int v = 0; v < (1 << VL_W); v++)
            for (int inc = 0; inc < 2; inc++)
                for (int f = 0; f <= MAXVL; f++)
                    run_case(v, 1'b0, 0, bit'(inc), f, bit'(((v + f) % 3) == 0));

        // strip mining: length from remaining count, vl_req ignored
        for (int r = 0; r <= 12; r++) run_case(3, 1'b1, r, 1'b0, MAXVL, 1'b0);
        run_case(3, 1'b1, 100, 1'b1, MAXVL, 1'b0);
        run_case(0, 1'b1, 65535, 1'b0, MAXVL, 1'b1);
        run_case(15, 1'b1, 5, 1'b0, 2, 1'b0);

        // R11: restart in the middle of a vector
        pulse_start(6, 1'b0, 0, 1'b0);
        for (int i = 0; i < 2; i++) begin
            elem_valid_i = 1'b1; elem_data_i = elem_val(i, MAXVL);
            @(negedge clk);
        end
        elem_valid_i = 1'b0;
        pulse_start(3, 1'b0, 0, 1'b0);
        chk("R11 mask cleared", int'(wr_mask_o), 0);
        for (int i = 0; i < 3; i++) begin
            elem_valid_i = 1'b1; elem_data_i = elem_val(i, MAXVL);
            @(negedge clk);
        end
        elem_valid_i = 1'b0;
        chk("R11 restart done", int'(done_o), 1);
        chk("R11 restart vl", int'(vl_o), 3);
        chk("R11 restart mask", int'(wr_mask_o), 7);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule